// File: doc/BRIEF.md
# Geometric Inductance Trimmer

This block holds a running estimate of the load inductance used by a current controller. It trims that estimate by a fixed step once per sample. There is no arithmetic identification. The direction of each trim comes only from the angular order of three space vectors:

- the current increment seen at the previous sample;
- the current increment seen at the present sample;
- the residual voltage left after the inductive drop predicted with the present estimate is removed.

The three vectors arrive already quantized to angular sectors, together with a flag for each one that marks it as too short to trust. A sample strobe and a validity qualifier also arrive with them. The qualifier is driven low upstream whenever the back-EMF change cannot be neglected beside the inductive terms.

The estimate starts from a programmable seed value. It is held between a programmable floor and ceiling. Each change of the estimate is followed one cycle later by a fresh coefficient, which is the estimate times a fixed reciprocal of the sample period. The controller uses this coefficient directly.

Top module: `ie_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, `le_o` loads `le_init`. At the first edge after release, `coef_o` equals floor(`le_o`*RECIP/2^RSH), with RECIP=200 and RSH=8 by default.
- R2: A sector code s (0 to 35) covers the directions from 10*s to 10*s+10 degrees, counted counterclockwise. A vector lies between two others only when its sector is strictly inside the shorter arc joining their sectors, and that arc may wrap through sector 0. A vector outside that arc causes no trim.
- R3: When the residual is in the same sector as the present increment, the estimate is unchanged.
- R4: When the residual lies between the previous and present increments, a qualified sample lowers the estimate by `le_step`.
- R5: When the present increment lies between the previous increment and the residual, a qualified sample raises the estimate by `le_step`.
- R6: A sample taken with `qual_ok` low leaves the estimate unchanged.
- R7: A sample taken with any of `tiny_prev`, `tiny_cur` or `tiny_res` high leaves the estimate unchanged.
- R8: When `smp_vld` is low, the estimate is unchanged, whatever the other inputs are.
- R9: A raise never takes the estimate above `le_max`, and a lower never takes it below `le_min`. At a bound the estimate saturates at that bound.
- R10: After each trim decision, `coef_o` is recomputed on the next edge. Otherwise `coef_o` holds its value.
- R11: The estimate is unchanged in three cases: the two increments share a sector, they are exactly 18 sectors apart, or any sector code is 36 or more.
- R12: The estimate changes at the clock edge where `smp_vld` is sampled high. The new coefficient appears one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_vld | input | 1 | One-cycle sample strobe |
| qual_ok | input | 1 | High when a trim is allowed for this sample |
| sec_prev | input | 6 | Sector of the previous current increment |
| sec_cur | input | 6 | Sector of the present current increment |
| sec_res | input | 6 | Sector of the residual voltage |
| tiny_prev | input | 1 | Previous increment too short |
| tiny_cur | input | 1 | Present increment too short |
| tiny_res | input | 1 | Residual too short |
| le_init | input | 16 | Seed value for the estimate |
| le_min | input | 16 | Floor of the estimate |
| le_max | input | 16 | Ceiling of the estimate |
| le_step | input | 16 | Size of one trim step |
| le_o | output | 16 | Inductance estimate |
| coef_o | output | 24 | Estimate times the reciprocal of the sample period |

## Verification
The hardest cases to reach are the arrangements whose shorter arc wraps through sector 0 or runs clockwise. In these cases a naive comparison of sector codes picks the wrong order. Directed samples place the bounding vectors on both sides of sector 0 and in descending order. The clockwise cases use residuals on the inner and outer side of the present increment. Saturation is reached by lowering the ceiling or raising the floor next to the running estimate, so a single step overshoots. After the directed samples, a long pseudo-random sequence is checked against a model that walks the arc sector by sector.

// File: rtl/ie_pkg.sv
package ie_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_DEC  = 2'd1,
        ACT_INC  = 2'd2
    } act_e;

    // forward (counterclockwise) sector distance from a to b
    function automatic int sec_fwd(input int a, input int b, input int n);
        return (b >= a) ? (b - a) : (b + n - a);
    endfunction

    // x strictly inside the shorter arc joining a and b (R2)
    function automatic logic arc_holds(input int a, input int b, input int x, input int n);
        int   dab;
        int   dx;
        logic r;
        dab = sec_fwd(a, b, n);
        r   = 1'b0;
        if (dab != 0 && 2 * dab != n) begin
            if (2 * dab < n) begin
                dx = sec_fwd(a, x, n);
                r  = (dx != 0) && (dx < dab);
            end else begin
                dx = sec_fwd(b, x, n);
                r  = (dx != 0) && (dx < n - dab);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/ie_arc_judge.sv
module ie_arc_judge
    import ie_pkg::*;
#(
    parameter  int SECTORS = 36,
    localparam int SW      = $clog2(SECTORS)
) (
    input  logic          smp_i,
    input  logic          qual_i,
    input  logic [SW-1:0] prev_i,
    input  logic [SW-1:0] cur_i,
    input  logic [SW-1:0] res_i,
    input  logic [2:0]    tiny_i,
    output act_e          act_o
);

    always_comb begin
        int   p;
        int   c;
        int   r;
        logic ok;
        logic shrink;
        logic grow;
        p  = int'(prev_i);
        c  = int'(cur_i);
        r  = int'(res_i);
        // R6 R7 R8 R11 gating
        ok = smp_i && qual_i && (tiny_i == 3'b000) &&
             (p < SECTORS) && (c < SECTORS) && (r < SECTORS);
        shrink = arc_holds(p, c, r, SECTORS);   // R4
        grow   = arc_holds(p, r, c, SECTORS);   // R5
        act_o  = ACT_HOLD;
        if (ok && r != c) begin                 // R3
            if (shrink)    act_o = ACT_DEC;
            else if (grow) act_o = ACT_INC;
        end
    end

endmodule

// File: rtl/ie_le_acc.sv
module ie_le_acc
    import ie_pkg::*;
#(
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  act_e          act_i,
    input  logic [LW-1:0] init_i,
    input  logic [LW-1:0] min_i,
    input  logic [LW-1:0] max_i,
    input  logic [LW-1:0] step_i,
    output logic [LW-1:0] le_o,
    output logic          upd_o
);

    localparam int EW = LW + 1;

    typedef struct packed {
        logic [LW-1:0] le;
        logic          upd;
    } acc_t;

    acc_t st_d, st_q;

    always_comb begin
        logic [EW-1:0] up;
        logic [EW-1:0] lo_lim;
        up     = {1'b0, st_q.le} + {1'b0, step_i};
        lo_lim = {1'b0, min_i} + {1'b0, step_i};
        st_d     = st_q;
        st_d.upd = 1'b0;
        case (act_i)
            ACT_INC: begin
                st_d.le  = (up > {1'b0, max_i}) ? max_i : up[LW-1:0];
                st_d.upd = 1'b1;
            end
            ACT_DEC: begin
                st_d.le  = ({1'b0, st_q.le} < lo_lim) ? min_i : (st_q.le - step_i);
                st_d.upd = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{le: init_i, upd: 1'b1};   // R1
        else        st_q <= st_d;
    end

    assign le_o  = st_q.le;
    assign upd_o = st_q.upd;

    a_r9_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == ACT_INC) |=> (le_o <= $past(max_i)));

    a_r9_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == ACT_DEC) |=> (le_o >= $past(min_i)));

    a_r12_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i != ACT_HOLD) |=>
            (({1'b0, le_o} <= {1'b0, $past(le_o)} + {1'b0, $past(step_i)}) &&
             ({1'b0, le_o} + {1'b0, $past(step_i)} >= {1'b0, $past(le_o)})));

    a_r3_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == ACT_HOLD) |=> $stable(le_o));

endmodule

// File: rtl/ie_coef_mul.sv
module ie_coef_mul #(
    parameter  int LW    = 16,
    parameter  int RW    = 16,
    parameter  int RSH   = 8,
    parameter  int RECIP = 200,
    localparam int PW    = LW + RW,
    localparam int CW    = PW - RSH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_i,
    input  logic [LW-1:0] le_i,
    output logic [CW-1:0] coef_o
);

    localparam logic [RW-1:0] RECIP_C = RW'(RECIP);

    logic [CW-1:0] coef_d, coef_q;

    always_comb begin
        logic [PW-1:0] prod;
        prod   = {{RW{1'b0}}, le_i} * {{LW{1'b0}}, RECIP_C};
        coef_d = upd_i ? prod[PW-1:RSH] : coef_q;   // R10
    end

    always_ff @(posedge clk) begin
        if (!rst_n) coef_q <= '0;
        else        coef_q <= coef_d;
    end

    assign coef_o = coef_q;

    a_r10_coef_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i |=> $stable(coef_o));

endmodule

// File: rtl/ie_top.sv
module ie_top
    import ie_pkg::*;
#(
    parameter  int SECTORS = 36,
    parameter  int LW      = 16,
    parameter  int RW      = 16,
    parameter  int RSH     = 8,
    parameter  int RECIP   = 200,
    localparam int SW      = $clog2(SECTORS),
    localparam int CW      = LW + RW - RSH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_vld,
    input  logic          qual_ok,
    input  logic [SW-1:0] sec_prev,
    input  logic [SW-1:0] sec_cur,
    input  logic [SW-1:0] sec_res,
    input  logic          tiny_prev,
    input  logic          tiny_cur,
    input  logic          tiny_res,
    input  logic [LW-1:0] le_init,
    input  logic [LW-1:0] le_min,
    input  logic [LW-1:0] le_max,
    input  logic [LW-1:0] le_step,
    output logic [LW-1:0] le_o,
    output logic [CW-1:0] coef_o
);

    act_e act;
    logic upd;

    ie_arc_judge #(.SECTORS(SECTORS)) u_judge (
        .smp_i  (smp_vld),
        .qual_i (qual_ok),
        .prev_i (sec_prev),
        .cur_i  (sec_cur),
        .res_i  (sec_res),
        .tiny_i ({tiny_res, tiny_cur, tiny_prev}),
        .act_o  (act)
    );

    ie_le_acc #(.LW(LW)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .act_i  (act),
        .init_i (le_init),
        .min_i  (le_min),
        .max_i  (le_max),
        .step_i (le_step),
        .le_o   (le_o),
        .upd_o  (upd)
    );

    ie_coef_mul #(.LW(LW), .RW(RW), .RSH(RSH), .RECIP(RECIP)) u_coef (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd_i  (upd),
        .le_i   (le_o),
        .coef_o (coef_o)
    );

    a_r6_unqualified_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !qual_ok) |=> $stable(le_o));

    a_r7_tiny_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && (tiny_prev || tiny_cur || tiny_res)) |=> $stable(le_o));

    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> $stable(le_o));

    a_r3_aligned_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && sec_res == sec_cur) |=> $stable(le_o));

    a_r11_same_sector_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && sec_prev == sec_cur) |=> $stable(le_o));

endmodule

// File: tb/ie_top_bench.sv
`timescale 1ns/1ps
module ie_top_bench;

    localparam int NS = 36;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld = 1'b0;
    logic        qual_ok = 1'b0;
    logic [5:0]  sec_prev = '0, sec_cur = '0, sec_res = '0;
    logic        tiny_prev = 1'b0, tiny_cur = 1'b0, tiny_res = 1'b0;
    logic [15:0] le_init = 16'd100, le_min = 16'd40, le_max = 16'd160, le_step = 16'd5;
    logic [15:0] le_o;
    logic [23:0] coef_o;

    always #2.5 clk = ~clk;

    ie_top u_ie_top (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .qual_ok(qual_ok),
        .sec_prev(sec_prev), .sec_cur(sec_cur), .sec_res(sec_res),
        .tiny_prev(tiny_prev), .tiny_cur(tiny_cur), .tiny_res(tiny_res),
        .le_init(le_init), .le_min(le_min), .le_max(le_max), .le_step(le_step),
        .le_o(le_o), .coef_o(coef_o)
    );

    typedef struct {
        int    le;
        int    coef;
        string tag;
    } exp_t;

    exp_t  sb[$];
    event  chk_ev;
    int    n_chk = 0;
    int    n_bad = 0;
    int    le_m  = 100;
    bit    done  = 1'b0;

    function automatic bit m_between(int a, int b, int x);
        int fwd = 0;
        int k   = a;
        while (k != b) begin k = (k + 1) % NS; fwd++; end
        if (fwd == 0 || fwd == NS / 2) return 1'b0;
        if (fwd < NS / 2) begin
            for (int s = 1; s < fwd; s++) if ((a + s) % NS == x) return 1'b1;
        end else begin
            for (int s = 1; s < NS - fwd; s++) if ((a - s + NS) % NS == x) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic int m_coef(int le);
        return (le * 200) >> 8;
    endfunction

    task automatic push_check(string tag);
        exp_t e;
        e.le = le_m; e.coef = m_coef(le_m); e.tag = tag;
        sb.push_back(e);
        ->chk_ev;
    endtask

    task automatic apply(int p, int c, int r, bit q, bit t0, bit t1, bit t2, bit stb, string tag);
        bit ok;
        @(negedge clk);
        sec_prev = 6'(p); sec_cur = 6'(c); sec_res = 6'(r);
        qual_ok = q; tiny_prev = t0; tiny_cur = t1; tiny_res = t2;
        smp_vld = stb;
        ok = stb && q && !t0 && !t1 && !t2 && p < NS && c < NS && r < NS && r != c;
        if (ok) begin
            if (m_between(p, c, r)) begin
                le_m = (le_m < int'(le_min) + int'(le_step)) ? int'(le_min) : le_m - int'(le_step);
            end else if (m_between(p, r, c)) begin
                le_m = (le_m + int'(le_step) > int'(le_max)) ? int'(le_max) : le_m + int'(le_step);
            end
        end
        @(negedge clk);
        smp_vld = 1'b0;
        @(negedge clk);
        push_check(tag);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(chk_ev);
            e = sb.pop_front();
            n_chk++;
            if (int'(le_o) != e.le || int'(coef_o) != e.coef) begin
                n_bad++;
                $display("FAIL %s: le=%0d coef=%0d expected le=%0d coef=%0d",
                         e.tag, le_o, coef_o, e.le, e.coef);
            end
        end
    end

    initial begin : watchdog
        #1000000;
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : driver
        int lcg;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        push_check("R1 reset seed and coefficient");

        apply(0, 6, 3, 1, 0, 0, 0, 1, "R4 residual inside arc lowers");
        apply(0, 6, 10, 1, 0, 0, 0, 1, "R5 present inside arc raises");
        apply(0, 6, 6, 1, 0, 0, 0, 1, "R3 aligned holds");
        apply(34, 2, 0, 1, 0, 0, 0, 1, "R4 wrap through sector 0 lowers");
        apply(10, 4, 1, 1, 0, 0, 0, 1, "R5 clockwise arc raises");
        apply(10, 4, 7, 1, 0, 0, 0, 1, "R4 clockwise arc lowers");
        apply(0, 6, 3, 0, 0, 0, 0, 1, "R6 unqualified sample holds");
        apply(0, 6, 3, 1, 1, 0, 0, 1, "R7 tiny previous holds");
        apply(0, 6, 10, 1, 0, 1, 0, 1, "R7 tiny present holds");
        apply(0, 6, 3, 1, 0, 0, 1, 1, "R7 tiny residual holds");
        apply(5, 5, 9, 1, 0, 0, 0, 1, "R11 same sector holds");
        apply(0, 18, 9, 1, 0, 0, 0, 1, "R11 opposite increments hold");
        apply(40, 6, 3, 1, 0, 0, 0, 1, "R11 out-of-range sector holds");
        apply(0, 6, 10, 1, 0, 0, 0, 0, "R8 no strobe holds");
        apply(0, 6, 20, 1, 0, 0, 0, 1, "R2 residual outside short arc holds");
        apply(33, 1, 35, 1, 0, 0, 0, 1, "R2 wrap residual inside lowers");

        le_max = 16'(le_m + 7);
        apply(0, 6, 10, 1, 0, 0, 0, 1, "R9 raise below ceiling");
        apply(0, 6, 10, 1, 0, 0, 0, 1, "R9 raise saturates at ceiling");
        apply(0, 6, 10, 1, 0, 0, 0, 1, "R9 raise at ceiling stays");
        le_min = 16'(le_m - 9);
        apply(0, 6, 3, 1, 0, 0, 0, 1, "R9 lower above floor");
        apply(0, 6, 3, 1, 0, 0, 0, 1, "R9 lower saturates at floor");
        apply(0, 6, 3, 1, 0, 0, 0, 1, "R9 lower at floor stays");

        le_min = 16'd40; le_max = 16'd160;
        lcg = 12345;
        for (int i = 0; i < 300; i++) begin
            int p, c, r, qq, tt;
            lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff; p  = (lcg >> 8) % NS;
            lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff; c  = (lcg >> 8) % NS;
            lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff; r  = (lcg >> 8) % NS;
            lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff; qq = (lcg >> 8) % 8;
            lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff; tt = (lcg >> 8) % 16;
            apply(p, c, r, qq != 0, tt == 1, tt == 2, tt == 3, 1, "R10 R12 sweep estimate and coefficient");
        end

        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule